// File: doc/BRIEF.md
# Settling Debouncer with Event Totalizer

This block cleans up one asynchronous digital input and counts its rising transitions. The input first passes through a two-flop synchronizer. A settle chain (a small shift register stepped by a clock prescaler) then decides when a new level has been held long enough to be trusted. The prescaler and the chain run only while the synchronized input disagrees with the chain's last stage, which is the settled output. If the input goes back to the settled level before the new level has travelled the whole chain, the prescaler restarts from zero and every stage is refilled with the settled level. A glitch therefore leaves no trace, and a later change must wait the full settle time again.

A source select picks what the totalizer counts. With the select low, the totalizer counts rising edges of the synchronized raw input. With the select high, it counts rising edges of the settled output. The totalizer is a wrapping counter with a sticky overflow flag. A synchronous clear resets both.

With the defaults, a 1.2288 MHz clock is divided by 256 to give a 4.8 kHz step, and the chain has eight stages, so a level must be held for 2048 clocks (about 1.67 ms) before it appears at the output. All timing and widths are parameters, so a bench can shorten the settle time. There is no data stream here. Every pin is a plain control or status pin, so no valid/ready handshake or back-pressure applies.

Top module: `debounced_totalizer`

## Requirements
- R1: After reset, `settled_level`, `tally` and `tally_wrapped` are all zero.
- R2: `settled_level` takes a new value only after the synchronized input has differed from it for SHIFT_TAPS*PRESCALE_DIV consecutive clocks. Counting the first clock edge that samples the changed `sense_in` as edge 1, the output changes on edge SHIFT_TAPS*PRESCALE_DIV+2.
- R3: While the synchronized input equals `settled_level`, the prescaler and the chain stay idle and `settled_level` holds.
- R4: If the synchronized input returns to `settled_level` before a change completes, the prescaler is cleared and every chain stage is reloaded with `settled_level`. A later change then needs the full SHIFT_TAPS*PRESCALE_DIV clocks, counted from that change.
- R5: When `count_settled` is 0 (raw source), `tally` increases by one for each rising edge of the synchronized input, including a pulse only one clock long. Counting as in R2, the increment appears on edge 3.
- R6: When `count_settled` is 1 (settled source), `tally` increases by one on the clock edge after `settled_level` rises. Pulses shorter than the settle time, and falling edges, add nothing.
- R7: Changing `count_settled` on its own never changes `tally`.
- R8: When `tally` is all ones, the next counted edge wraps it to zero and sets `tally_wrapped`. The flag stays set through later counts until a clear.
- R9: `tally_clr` high at a clock edge sets `tally` and `tally_wrapped` to zero. If a counted edge falls in the same cycle, the clear wins and that edge is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sense_in | input | 1 | Asynchronous digital input to debounce and count |
| count_settled | input | 1 | Totalizer source: 0 = synchronized raw input, 1 = settled output |
| tally_clr | input | 1 | Synchronous clear of the count and the wrap flag |
| settled_level | output | 1 | Debounced level (last chain stage) |
| tally | output | COUNT_W | Rising-edge event count |
| tally_wrapped | output | 1 | Sticky flag, set when the count wraps |

## Verification
The synchronous clear and a counted rising edge can land on the same clock edge, and the rule is that the clear wins. The bench raises the raw input in raw-source mode. It holds `tally_clr` high for exactly the third edge after the input change, which is the edge where the increment would otherwise land. A nonzero count from earlier events must then read zero with the flag low, and it must still read zero once the input has gone quiet, which shows the colliding edge was dropped rather than deferred.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  typedef enum logic {
    SRC_RAW     = 1'b0,
    SRC_SETTLED = 1'b1
  } tally_src_e;
endpackage

// File: rtl/dbt_sync.sv
module dbt_sync #(
  parameter int FLOPS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [FLOPS-1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage <= '0;
    else        stage <= {stage[FLOPS-2:0], d};
  end

  assign q = stage[FLOPS-1];
endmodule

// File: rtl/dbt_settle.sv
module dbt_settle #(
  parameter int TAPS = 8,
  parameter int DIV  = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  output logic settled
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);

  logic [TAPS-1:0] chain;
  logic [PW-1:0]   pre;
  logic            differ;
  logic            step;

  assign settled = chain[TAPS-1];
  assign differ  = sample ^ settled;
  assign step    = differ && (pre == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      pre   <= '0;
    end else if (!differ) begin
      // agreement or a reverted glitch: restart timing, refill with output
      pre   <= '0;
      chain <= {TAPS{settled}};
    end else if (step) begin
      pre   <= '0;
      chain <= {chain[TAPS-2:0], sample};
    end else begin
      pre   <= pre + 1'b1;
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !differ |=> $stable(settled));

  assert_new_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(settled) |-> settled == $past(sample));

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !differ |=> (pre == '0) && (chain == {TAPS{settled}}));
endmodule

// File: rtl/dbt_tally.sv
module dbt_tally
  import dbt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  tally_src_e   src,
  input  logic         raw,
  input  logic         settled,
  output logic [W-1:0] count,
  output logic         wrapped
);
  logic raw_q, set_q;
  logic raw_rise, set_rise, hit;

  assign raw_rise = raw & ~raw_q;
  assign set_rise = settled & ~set_q;
  // edge chosen per source so a select change cannot fake an edge
  assign hit = (src == SRC_SETTLED) ? set_rise : raw_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      set_q <= 1'b0;
    end else begin
      raw_q <= raw;
      set_q <= settled;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      wrapped <= 1'b0;
    end else if (clr) begin
      count   <= '0;
      wrapped <= 1'b0;
    end else if (hit) begin
      count <= count + 1'b1;
      if (&count) wrapped <= 1'b1;
    end
  end

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0) && !wrapped);

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !hit) |=> $stable(count));

  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && hit && (&count)) |=> (count == '0) && wrapped);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrapped && !clr) |=> wrapped);
endmodule

// File: rtl/debounced_totalizer.sv
module debounced_totalizer
  import dbt_pkg::*;
#(
  parameter int PRESCALE_DIV = 256,
  parameter int SHIFT_TAPS   = 8,
  parameter int COUNT_W      = 16,
  parameter int SYNC_FLOPS   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sense_in,
  input  logic               count_settled,
  input  logic               tally_clr,
  output logic               settled_level,
  output logic [COUNT_W-1:0] tally,
  output logic               tally_wrapped
);
  logic       sense_s;
  tally_src_e src;

  assign src = tally_src_e'(count_settled);

  dbt_sync #(.FLOPS(SYNC_FLOPS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sense_in),
    .q     (sense_s)
  );

  dbt_settle #(.TAPS(SHIFT_TAPS), .DIV(PRESCALE_DIV)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .sample  (sense_s),
    .settled (settled_level)
  );

  dbt_tally #(.W(COUNT_W)) u_tally (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tally_clr),
    .src     (src),
    .raw     (sense_s),
    .settled (settled_level),
    .count   (tally),
    .wrapped (tally_wrapped)
  );
endmodule

// File: tb/tb_debounced_totalizer.sv
module tb_debounced_totalizer;
  localparam int CLK_PERIOD = 10;
  localparam int DIV    = 4;
  localparam int TAPS   = 3;
  localparam int CW     = 4;
  localparam int SETTLE = DIV * TAPS;
  localparam int GAP    = 3 * SETTLE;

  typedef struct packed {
    logic       sel;
    logic [7:0] hi;
    logic [3:0] delta;
  } vec_t;

  // source select, high time in clocks, expected count increase
  localparam vec_t VECS [8] = '{
    '{1'b0, 8'd1,  4'd1},
    '{1'b0, 8'd5,  4'd1},
    '{1'b1, 8'd5,  4'd0},
    '{1'b1, 8'd11, 4'd0},
    '{1'b1, 8'd12, 4'd1},
    '{1'b1, 8'd13, 4'd1},
    '{1'b1, 8'd40, 4'd1},
    '{1'b0, 8'd40, 4'd1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sense_in = 1'b0;
  logic          count_settled = 1'b0;
  logic          tally_clr = 1'b0;
  logic          settled_level;
  logic [CW-1:0] tally;
  logic          tally_wrapped;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  debounced_totalizer #(
    .PRESCALE_DIV (DIV),
    .SHIFT_TAPS   (TAPS),
    .COUNT_W      (CW),
    .SYNC_FLOPS   (2)
  ) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .sense_in      (sense_in),
    .count_settled (count_settled),
    .tally_clr     (tally_clr),
    .settled_level (settled_level),
    .tally         (tally),
    .tally_wrapped (tally_wrapped)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      fails++;
      $display("FAIL all: watchdog expired actual=%0d expected<%0d", cycles, 100000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input int hi);
    @(negedge clk) sense_in = 1'b1;
    repeat (hi) @(negedge clk);
    sense_in = 1'b0;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk) tally_clr = 1'b1;
    @(negedge clk) tally_clr = 1'b0;
  endtask

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    check("R1 settled", int'(settled_level), 0);
    check("R1 tally", int'(tally), 0);
    check("R1 wrapped", int'(tally_wrapped), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release", int'(tally), 0);

    // table walk: R5 raw counting, R6 settled counting and glitch rejection
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) count_settled = VECS[i].sel;
      c0 = int'(tally);
      pulse(int'(VECS[i].hi));
      check(VECS[i].sel ? "R6 table" : "R5 table", int'(tally),
            (c0 + int'(VECS[i].delta)) % (1 << CW));
      check("R3 idle low", int'(settled_level), 0);
    end

    // R2 exact settle latency, then R6 one-edge count latency
    @(negedge clk) count_settled = 1'b1;
    c0 = int'(tally);
    sense_in = 1'b1;
    repeat (SETTLE + 1) @(posedge clk);
    #1 check("R2 not yet", int'(settled_level), 0);
    @(posedge clk);
    #1 check("R2 flipped", int'(settled_level), 1);
    check("R6 before", int'(tally), c0);
    @(posedge clk);
    #1 check("R6 counted", int'(tally), (c0 + 1) % (1 << CW));
    // R3 steady high holds output
    repeat (GAP) @(negedge clk);
    check("R3 hold high", int'(settled_level), 1);
    @(negedge clk) sense_in = 1'b0;
    repeat (GAP) @(negedge clk);
    check("R6 fall no count", int'(tally), (c0 + 1) % (1 << CW));

    // R4 glitch restarts the timer
    @(negedge clk) sense_in = 1'b1;
    repeat (8) @(negedge clk);
    sense_in = 1'b0;
    repeat (2) @(negedge clk);
    sense_in = 1'b1;
    repeat (SETTLE + 1) @(posedge clk);
    #1 check("R4 restarted", int'(settled_level), 0);
    @(posedge clk);
    #1 check("R4 full wait", int'(settled_level), 1);
    @(negedge clk) sense_in = 1'b0;
    repeat (GAP) @(negedge clk);

    // R5 raw increment latency
    @(negedge clk) count_settled = 1'b0;
    c0 = int'(tally);
    sense_in = 1'b1;
    repeat (2) @(posedge clk);
    #1 check("R5 not yet", int'(tally), c0);
    @(posedge clk);
    #1 check("R5 counted", int'(tally), (c0 + 1) % (1 << CW));
    @(negedge clk) sense_in = 1'b0;
    repeat (GAP) @(negedge clk);

    // R7 select changes while raw and settled differ
    @(negedge clk) count_settled = 1'b1;
    c0 = int'(tally);
    sense_in = 1'b1;
    repeat (4) @(negedge clk);
    count_settled = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 to raw", int'(tally), c0);
    repeat (GAP) @(negedge clk);
    count_settled = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 to settled", int'(tally), c0);
    sense_in = 1'b0;
    repeat (GAP) @(negedge clk);
    count_settled = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 back", int'(tally), c0);

    // R9 clear alone
    clear_all();
    check("R9 clear", int'(tally), 0);
    check("R9 clear flag", int'(tally_wrapped), 0);

    // R8 wrap and sticky flag
    for (int k = 0; k < (1 << CW) - 1; k++) pulse(1);
    check("R8 full", int'(tally), (1 << CW) - 1);
    check("R8 flag low", int'(tally_wrapped), 0);
    pulse(1);
    check("R8 wrapped", int'(tally), 0);
    check("R8 flag set", int'(tally_wrapped), 1);
    pulse(1);
    check("R8 sticky count", int'(tally), 1);
    check("R8 sticky flag", int'(tally_wrapped), 1);

    // R9 clear collides with a counted edge
    pulse(1);
    @(negedge clk) sense_in = 1'b1;
    repeat (2) @(negedge clk);
    tally_clr = 1'b1;
    @(negedge clk) tally_clr = 1'b0;
    check("R9 collide", int'(tally), 0);
    check("R9 collide flag", int'(tally_wrapped), 0);
    sense_in = 1'b0;
    repeat (GAP) @(negedge clk);
    check("R9 edge lost", int'(tally), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule